// File: doc/BRIEF.md
# Multi-Queue Stream Rate Limiter

This block sits in the egress path of up to five independent packet streams. Each queue has a valid/ready input stream and an output stream that carries the same beats. A memory-mapped AXI4-Lite register bank sets three things for each queue: a level-held soft reset, a limiting enable and a rate code. When limiting is on, each queue lets a beat through only in some clock cycles. Its throughput is then the line rate divided by a power of two.

Each queue has a free-running cycle counter that marks its pass windows. A beat can move only in a cycle where the low N bits of that counter are all zero, where N is the rate code. Outside a pass window the block lowers valid toward the output and ready toward the input together. Beats are held back, never dropped, reordered or split, and the payload fields pass through untouched. With limiting off, a queue behaves as a wire.

Top module: `srl_top`

## Requirements
- R1: When a queue's enable bit (bit 0 at slot offset 0x4) is 0 and its soft reset word is zero, m_tvalid equals s_tvalid and s_tready equals m_tready for that queue in every cycle.
- R2: When a queue is enabled with rate code N in 0..MAX_RATE (default 7), a handshake happens only in cycles where the low N bits of that queue's counter are zero. With input valid and output ready held high, exactly W/2^N beats pass in any W consecutive cycles, where W is a multiple of 2^N. Code 0 is full rate.
- R3: A rate code above MAX_RATE acts as MAX_RATE. Reading the rate register returns the 4-bit code as written.
- R4: While a queue's soft reset word (slot offset 0x0) holds any nonzero value, that queue's m_tvalid and s_tready stay 0 and its counter stays at zero.
- R5: m_tdata, m_tkeep, m_tuser and m_tlast always equal the matching input fields. An output handshake happens in exactly the cycles with an input handshake, so beats are neither lost nor reordered.
- R6: Queue i's registers sit at byte address i*12. Offset 0x0 holds the 32-bit soft reset word, offset 0x4 holds the enable in bit 0, and offset 0x8 holds the rate code in bits 3:0. A read returns the stored value with all other bits zero.
- R7: A read of an unaligned address, of offsets 0x1-0x3, 0x5-0x7 or 0x9-0xB within a slot, or of a slot index at or above NUM_Q returns 0. A write to any of these has no effect. Every write and read response is OKAY (2'b00).
- R8: A write is accepted in the cycle where awvalid and wvalid are both high and no write response is pending. bvalid stays high until bready. rvalid and rdata stay unchanged until rready.
- R9: A synchronous low on rst_n clears every register. After reset all queues are disabled, at rate code 0 and out of soft reset.
- R10: Queues are independent. One queue's configuration and traffic do not change another queue's throughput.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awaddr | input | ADDR_W | Write address (byte, relative to the block) |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response (always OKAY) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response (always OKAY) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| s_tdata | input | NUM_Q x DATA_W | Input beat data, per queue |
| s_tkeep | input | NUM_Q x DATA_W/8 | Input byte enables, per queue |
| s_tuser | input | NUM_Q x USER_W | Input sideband, per queue |
| s_tlast | input | NUM_Q | Input end of packet, per queue |
| s_tvalid | input | NUM_Q | Input valid, per queue |
| s_tready | output | NUM_Q | Input ready, per queue |
| m_tdata | output | NUM_Q x DATA_W | Output beat data, per queue |
| m_tkeep | output | NUM_Q x DATA_W/8 | Output byte enables, per queue |
| m_tuser | output | NUM_Q x USER_W | Output sideband, per queue |
| m_tlast | output | NUM_Q | Output end of packet, per queue |
| m_tvalid | output | NUM_Q | Output valid, per queue |
| m_tready | input | NUM_Q | Output ready, per queue |

## Verification
A register write that changes a queue's rate or soft reset can land in the same cycle as a beat handshake on that queue, so configuration and forwarding then overlap. The bench provokes this by issuing register writes from a parallel thread while a queue runs continuous traffic. One write moves the rate code, another pulses soft reset and a third clears it. The bench judges the run by two checks: input and output handshake counts must be equal, and the sequence-numbered payload must arrive in order with no gap. The checker adds a property that two limited handshakes are never adjacent, even across a rate change.

// File: rtl/srl_pkg.sv
package srl_pkg;

  localparam int unsigned REG_W      = 32;
  localparam int unsigned SLOT_BYTES = 12;

  typedef enum logic [1:0] {
    FLD_SRST = 2'd0,
    FLD_EN   = 2'd1,
    FLD_RATE = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  // queue slot index from a byte address
  function automatic int unsigned slot_of(input int unsigned addr);
    return addr / SLOT_BYTES;
  endfunction

  // register field inside a slot; anything unaligned is unmapped
  function automatic fld_e field_of(input int unsigned addr);
    int unsigned r;
    r = addr % SLOT_BYTES;
    case (r)
      0:       return FLD_SRST;
      4:       return FLD_EN;
      8:       return FLD_RATE;
      default: return FLD_NONE;
    endcase
  endfunction

  // codes beyond the counter width saturate
  function automatic int unsigned clamp_code(input int unsigned code,
                                             input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction

  // a window is open when the low 'code' counter bits are all zero
  function automatic logic pass_window(input logic [31:0] cnt,
                                       input int unsigned code);
    logic [31:0] mask;
    mask = (32'd1 << code) - 32'd1;
    return (cnt & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/srl_csr.sv
module srl_csr
  import srl_pkg::*;
#(
  parameter int unsigned NUM_Q   = 5,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RATE_FW = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 awaddr,
  input  logic                              awvalid,
  output logic                              awready,
  input  logic [REG_W-1:0]                  wdata,
  input  logic                              wvalid,
  output logic                              wready,
  output logic [1:0]                        bresp,
  output logic                              bvalid,
  input  logic                              bready,
  input  logic [ADDR_W-1:0]                 araddr,
  input  logic                              arvalid,
  output logic                              arready,
  output logic [REG_W-1:0]                  rdata,
  output logic [1:0]                        rresp,
  output logic                              rvalid,
  input  logic                              rready,
  output logic [NUM_Q-1:0]                  cfg_srst,
  output logic [NUM_Q-1:0]                  cfg_en,
  output logic [NUM_Q-1:0][RATE_FW-1:0]     cfg_code
);

  logic [NUM_Q-1:0][REG_W-1:0]   srst_q;
  logic [NUM_Q-1:0]              en_q;
  logic [NUM_Q-1:0][RATE_FW-1:0] code_q;

  logic        wr_fire, rd_fire;
  int unsigned wr_slot, rd_slot;
  fld_e        wr_fld, rd_fld;
  logic [REG_W-1:0] rd_word;

  assign wr_fire = awvalid & wvalid & ~bvalid;
  assign awready = wr_fire;
  assign wready  = wr_fire;
  assign rd_fire = arvalid & ~rvalid;
  assign arready = rd_fire;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;

  always_comb begin
    wr_slot = slot_of(32'(awaddr));
    wr_fld  = field_of(32'(awaddr));
    rd_slot = slot_of(32'(araddr));
    rd_fld  = field_of(32'(araddr));
  end

  // per-queue register slots
  for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
    logic hit;
    assign hit = wr_fire && (wr_slot == q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srst_q[q] <= '0;
        en_q[q]   <= 1'b0;
        code_q[q] <= '0;
      end else if (hit) begin
        case (wr_fld)
          FLD_SRST: srst_q[q] <= wdata;
          FLD_EN:   en_q[q]   <= wdata[0];
          FLD_RATE: code_q[q] <= wdata[RATE_FW-1:0];
          default:  ;
        endcase
      end
    end

    assign cfg_srst[q] = |srst_q[q];
    assign cfg_en[q]   = en_q[q];
    assign cfg_code[q] = code_q[q];
  end

  // read multiplexer
  always_comb begin
    rd_word = '0;
    for (int q = 0; q < int'(NUM_Q); q++) begin
      if (rd_slot == q) begin
        case (rd_fld)
          FLD_SRST: rd_word = srst_q[q];
          FLD_EN:   rd_word = {{(REG_W-1){1'b0}}, en_q[q]};
          FLD_RATE: rd_word = {{(REG_W-RATE_FW){1'b0}}, code_q[q]};
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_fire)     bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;

      if (rd_fire) begin
        rvalid <= 1'b1;
        rdata  <= rd_word;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/srl_gate.sv
module srl_gate
  import srl_pkg::*;
#(
  parameter int unsigned MAX_RATE = 7,
  parameter int unsigned RATE_FW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               en,
  input  logic [RATE_FW-1:0] code,
  output logic               open
);

  localparam int unsigned CNT_W = (MAX_RATE > 0) ? MAX_RATE : 1;

  logic [CNT_W-1:0] cnt;
  logic             win;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  assign win  = pass_window(32'(cnt), clamp_code(32'(code), MAX_RATE));
  assign open = ~srst & (~en | win);

endmodule

// File: rtl/srl_top.sv
module srl_top
  import srl_pkg::*;
#(
  parameter int unsigned NUM_Q    = 5,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned USER_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned MAX_RATE = 7,
  parameter int unsigned RATE_FW  = 4,
  localparam int unsigned KEEP_W  = DATA_W / 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               awaddr,
  input  logic                            awvalid,
  output logic                            awready,
  input  logic [31:0]                     wdata,
  input  logic                            wvalid,
  output logic                            wready,
  output logic [1:0]                      bresp,
  output logic                            bvalid,
  input  logic                            bready,
  input  logic [ADDR_W-1:0]               araddr,
  input  logic                            arvalid,
  output logic                            arready,
  output logic [31:0]                     rdata,
  output logic [1:0]                      rresp,
  output logic                            rvalid,
  input  logic                            rready,
  input  logic [NUM_Q-1:0][DATA_W-1:0]    s_tdata,
  input  logic [NUM_Q-1:0][KEEP_W-1:0]    s_tkeep,
  input  logic [NUM_Q-1:0][USER_W-1:0]    s_tuser,
  input  logic [NUM_Q-1:0]                s_tlast,
  input  logic [NUM_Q-1:0]                s_tvalid,
  output logic [NUM_Q-1:0]                s_tready,
  output logic [NUM_Q-1:0][DATA_W-1:0]    m_tdata,
  output logic [NUM_Q-1:0][KEEP_W-1:0]    m_tkeep,
  output logic [NUM_Q-1:0][USER_W-1:0]    m_tuser,
  output logic [NUM_Q-1:0]                m_tlast,
  output logic [NUM_Q-1:0]                m_tvalid,
  input  logic [NUM_Q-1:0]                m_tready
);

  // named internal events for the checker
  logic [NUM_Q-1:0]              q_srst;
  logic [NUM_Q-1:0]              q_en;
  logic [NUM_Q-1:0][RATE_FW-1:0] q_code;
  logic [NUM_Q-1:0]              q_open;

  srl_csr #(
    .NUM_Q   (NUM_Q),
    .ADDR_W  (ADDR_W),
    .RATE_FW (RATE_FW)
  ) csr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .awaddr   (awaddr),
    .awvalid  (awvalid),
    .awready  (awready),
    .wdata    (wdata),
    .wvalid   (wvalid),
    .wready   (wready),
    .bresp    (bresp),
    .bvalid   (bvalid),
    .bready   (bready),
    .araddr   (araddr),
    .arvalid  (arvalid),
    .arready  (arready),
    .rdata    (rdata),
    .rresp    (rresp),
    .rvalid   (rvalid),
    .rready   (rready),
    .cfg_srst (q_srst),
    .cfg_en   (q_en),
    .cfg_code (q_code)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    srl_gate #(
      .MAX_RATE (MAX_RATE),
      .RATE_FW  (RATE_FW)
    ) gate_i (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (q_srst[q]),
      .en    (q_en[q]),
      .code  (q_code[q]),
      .open  (q_open[q])
    );

    assign m_tvalid[q] = s_tvalid[q] & q_open[q];
    assign s_tready[q] = m_tready[q] & q_open[q];
    assign m_tdata[q]  = s_tdata[q];
    assign m_tkeep[q]  = s_tkeep[q];
    assign m_tuser[q]  = s_tuser[q];
    assign m_tlast[q]  = s_tlast[q];
  end

endmodule

// File: rtl/srl_chk.sv
module srl_chk #(
  parameter int unsigned NUM_Q   = 5,
  parameter int unsigned RATE_FW = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_Q-1:0]              s_tvalid,
  input logic [NUM_Q-1:0]              s_tready,
  input logic [NUM_Q-1:0]              m_tvalid,
  input logic [NUM_Q-1:0]              m_tready,
  input logic [NUM_Q-1:0]              q_srst,
  input logic [NUM_Q-1:0]              q_en,
  input logic [NUM_Q-1:0][RATE_FW-1:0] q_code,
  input logic                          bvalid,
  input logic                          bready,
  input logic                          rvalid,
  input logic                          rready,
  input logic [31:0]                   rdata
);

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    logic xin, xout, lim;
    assign xin  = s_tvalid[i] & s_tready[i];
    assign xout = m_tvalid[i] & m_tready[i];
    assign lim  = q_en[i] & (q_code[i] != '0);

    // R1
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_srst[i] && !q_en[i]) |-> (s_tready[i] == m_tready[i] && m_tvalid[i] == s_tvalid[i]));

    // R2
    limited_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xout && lim && !q_srst[i]) |=> !(xout && lim));

    // R4
    srst_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_srst[i] |-> (!m_tvalid[i] && !s_tready[i]));

    // R5
    xfer_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xin == xout);
  end

  // R8
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

bind srl_top srl_chk #(
  .NUM_Q   (NUM_Q),
  .RATE_FW (RATE_FW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .q_srst   (q_srst),
  .q_en     (q_en),
  .q_code   (q_code),
  .bvalid   (bvalid),
  .bready   (bready),
  .rvalid   (rvalid),
  .rready   (rready),
  .rdata    (rdata)
);

// File: tb/srl_top_tb.sv
module srl_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NQ  = 3;
  localparam int DW  = 32;
  localparam int UW  = 4;
  localparam int KW  = DW / 8;
  localparam int AW  = 8;
  localparam int WIN = 128;

  typedef struct packed {
    logic [1:0] q;
    logic       en;
    logic [3:0] code;
    logic [8:0] exp;
  } vec_t;

  // queue, enable, rate code, expected beats in WIN cycles
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b1, 4'd0, 9'd128},   // R2 full rate
    '{2'd0, 1'b1, 4'd1, 9'd64},    // R2 half
    '{2'd1, 1'b1, 4'd2, 9'd32},    // R2 quarter
    '{2'd2, 1'b1, 4'd3, 9'd16},    // R2 eighth
    '{2'd1, 1'b1, 4'd6, 9'd2},     // R2 1/64
    '{2'd2, 1'b1, 4'd7, 9'd1},     // R2 max code
    '{2'd0, 1'b1, 4'd9, 9'd1},     // R3 saturates to 7
    '{2'd1, 1'b0, 4'd5, 9'd128}    // R1 disabled ignores code
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [NQ-1:0][DW-1:0] s_tdata = '0;
  logic [NQ-1:0][KW-1:0] s_tkeep = '0;
  logic [NQ-1:0][UW-1:0] s_tuser = '0;
  logic [NQ-1:0] s_tlast = '0, s_tvalid = '0, m_tready = '0;
  logic [NQ-1:0][DW-1:0] m_tdata;
  logic [NQ-1:0][KW-1:0] m_tkeep;
  logic [NQ-1:0][UW-1:0] m_tuser;
  logic [NQ-1:0] m_tlast, m_tvalid, s_tready;

  int checks = 0;
  int failures = 0;
  int resp_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srl_top #(
    .NUM_Q (NQ), .DATA_W (DW), .USER_W (UW), .ADDR_W (AW),
    .MAX_RATE (7), .RATE_FW (4)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .awaddr (awaddr), .awvalid (awvalid), .awready (awready),
    .wdata (wdata), .wvalid (wvalid), .wready (wready),
    .bresp (bresp), .bvalid (bvalid), .bready (bready),
    .araddr (araddr), .arvalid (arvalid), .arready (arready),
    .rdata (rdata), .rresp (rresp), .rvalid (rvalid), .rready (rready),
    .s_tdata (s_tdata), .s_tkeep (s_tkeep), .s_tuser (s_tuser),
    .s_tlast (s_tlast), .s_tvalid (s_tvalid), .s_tready (s_tready),
    .m_tdata (m_tdata), .m_tkeep (m_tkeep), .m_tuser (m_tuser),
    .m_tlast (m_tlast), .m_tvalid (m_tvalid), .m_tready (m_tready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic axi_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    awaddr = AW'(addr); wdata = data; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    #1;
    while (!bvalid) begin @(negedge clk); #1; end
    if (bresp != 2'b00) resp_bad++;
    @(posedge clk);
  endtask

  task automatic axi_rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    araddr = AW'(addr); arvalid = 1'b1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    arvalid = 1'b0;
    #1;
    while (!rvalid) begin @(negedge clk); #1; end
    data = rdata;
    if (rresp != 2'b00) resp_bad++;
    @(posedge clk);
  endtask

  // continuous traffic on queue q for n cycles; counts handshakes and
  // payload or ordering errors at the output
  task automatic run_q(input int q, input int n, output int nin, output int nout,
                       output int bad);
    logic [31:0] seq = 32'h1000 * (q + 1);
    logic [31:0] exp_out = seq;
    bit hs;
    nin = 0; nout = 0; bad = 0;
    @(negedge clk);
    s_tdata[q] = seq; s_tkeep[q] = KW'(seq); s_tuser[q] = UW'(seq);
    s_tlast[q] = (seq[1:0] == 2'd3);
    s_tvalid[q] = 1'b1; m_tready[q] = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      hs = s_tvalid[q] && s_tready[q];
      if (hs) nin++;
      if (m_tvalid[q] && m_tready[q]) begin
        nout++;
        if (m_tdata[q] != exp_out) bad++;
        exp_out = exp_out + 1;
      end
      if (m_tdata[q] != s_tdata[q] || m_tkeep[q] != s_tkeep[q] ||
          m_tuser[q] != s_tuser[q] || m_tlast[q] != s_tlast[q]) bad++;
      @(negedge clk);
      if (hs) begin
        seq = seq + 1;
        s_tdata[q] = seq; s_tkeep[q] = KW'(seq); s_tuser[q] = UW'(seq);
        s_tlast[q] = (seq[1:0] == 2'd3);
      end
    end
    s_tvalid[q] = 1'b0; m_tready[q] = 1'b0;
  endtask

  task automatic run_all;
    logic [31:0] rd;
    int nin, nout, bad, nin2, nout2, bad2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state of every register
    for (int q = 0; q < NQ; q++) begin
      for (int f = 0; f < 3; f++) begin
        axi_rd(q*12 + f*4, rd);
        check(rd == 0, "R9 reset register", int'(rd), 0);
      end
    end

    // R6 readback of each field
    axi_wr(1*12 + 0, 32'hA5A5_0000);
    axi_rd(1*12 + 0, rd);
    check(rd == 32'hA5A5_0000, "R6 srst word readback", int'(rd), 32'hA5A5_0000);
    axi_wr(1*12 + 0, 32'h0);
    axi_wr(2*12 + 4, 32'hFFFF_FFFF);
    axi_rd(2*12 + 4, rd);
    check(rd == 1, "R6 enable bit readback", int'(rd), 1);
    axi_wr(2*12 + 4, 32'h0);

    // main table
    foreach (VECS[k]) begin
      int q;
      q = int'(VECS[k].q);
      axi_wr(q*12 + 4, {31'd0, VECS[k].en});
      axi_wr(q*12 + 8, {28'd0, VECS[k].code});
      axi_rd(q*12 + 8, rd);
      check(rd == 32'(VECS[k].code), "R3 rate readback", int'(rd), int'(VECS[k].code));
      run_q(q, WIN, nin, nout, bad);
      check(nout == int'(VECS[k].exp), "R2 beats per window", nout, int'(VECS[k].exp));
      check(bad == 0 && nin == nout, "R5 payload and handshake match", bad, 0);
      axi_wr(q*12 + 4, 32'h0);
      axi_wr(q*12 + 8, 32'h0);
    end

    // R4 soft reset held by a nonzero word (bit 8 only)
    axi_wr(0, 32'h0000_0100);
    run_q(0, 32, nin, nout, bad);
    check(nout == 0 && nin == 0, "R4 queue stalled in soft reset", nout, 0);
    axi_rd(0, rd);
    check(rd == 32'h100, "R6 soft reset word kept", int'(rd), 32'h100);
    axi_wr(0, 32'h0);
    run_q(0, WIN, nin, nout, bad);
    check(nout == WIN, "R1 full throughput after release", nout, WIN);

    // R10 two queues at once with different settings
    axi_wr(0*12 + 4, 32'h1);
    axi_wr(0*12 + 8, 32'h2);
    fork
      run_q(0, WIN, nin, nout, bad);
      run_q(1, WIN, nin2, nout2, bad2);
    join
    check(nout == 32, "R10 queue 0 limited", nout, 32);
    check(nout2 == WIN, "R10 queue 1 unaffected", nout2, WIN);
    axi_wr(0*12 + 4, 32'h0);
    axi_wr(0*12 + 8, 32'h0);

    // R7 unmapped reads and writes
    axi_wr(3*12 + 4, 32'h1);
    axi_rd(3*12 + 4, rd);
    check(rd == 0, "R7 slot above NUM_Q", int'(rd), 0);
    axi_wr(2*12 + 5, 32'h1);
    axi_rd(2*12 + 4, rd);
    check(rd == 0, "R7 unaligned write ignored", int'(rd), 0);
    axi_rd(2*12 + 9, rd);
    check(rd == 0, "R7 unaligned read zero", int'(rd), 0);

    // concurrency: register writes land during traffic on queue 2
    axi_wr(2*12 + 4, 32'h1);
    axi_wr(2*12 + 8, 32'h1);
    fork
      run_q(2, 300, nin, nout, bad);
      begin
        axi_wr(2*12 + 8, 32'h0);
        axi_wr(2*12 + 0, 32'h1);
        axi_wr(2*12 + 8, 32'h3);
        axi_wr(2*12 + 0, 32'h0);
      end
    join
    check(bad == 0 && nin == nout && nout > 0, "R5 order kept across config writes", bad, 0);
    axi_wr(2*12 + 4, 32'h0);
    axi_wr(2*12 + 8, 32'h0);

    // R8 response held while bready low
    @(negedge clk);
    bready = 1'b0;
    awaddr = AW'(8); wdata = 32'h5; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    repeat (3) @(negedge clk);
    check(bvalid == 1'b1, "R8 bvalid held", int'(bvalid), 1);
    bready = 1'b1;
    @(negedge clk);
    check(bvalid == 1'b0, "R8 bvalid cleared by bready", int'(bvalid), 0);

    // R8 read data held while rready low
    rready = 1'b0;
    araddr = AW'(8); arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    repeat (3) @(negedge clk);
    check(rvalid && rdata == 32'h5, "R8 rdata held", int'(rdata), 5);
    rready = 1'b1;
    @(negedge clk);

    // R9 reset mid-operation clears configuration
    axi_wr(1*12 + 4, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    axi_rd(8, rd);
    check(rd == 0, "R9 rate cleared by reset", int'(rd), 0);
    axi_rd(1*12 + 4, rd);
    check(rd == 0, "R9 enable cleared by reset", int'(rd), 0);

    check(resp_bad == 0, "R7 all responses OKAY", resp_bad, 0);
  endtask

  initial begin
    fork
      run_all;
      begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule